// File: doc/BRIEF.md
# Preemptive Three-Master Video Port Arbiter

This block lets three masters share the single byte-wide address/data port of a video display processor. The masters, in fixed priority order, are a pointer-sprite updater, the CPU and a block-copy DMA engine that reads bytes from DRAM and writes them to video memory. The display processor keeps one auto-incrementing write address. Every master therefore owns a private copy of that address, called its context.

Whenever the port's loaded address belongs to a different master, or was changed since it was loaded, the arbiter first issues a two-byte address setup from the context of the granted master. It then streams that master's data bytes. A higher-priority request can take the port at any byte boundary. The interrupted master later resumes at the exact next address, so interleaved streams never overwrite each other.

A programmable idle gap separates every port access, whichever master makes it. The DMA engine reports completion through a sticky flag that the CPU can read. The pointer-sprite master raises its request whenever the pointer moves; how the sprite data is computed lies outside this block.

Top module: `vdp_port_arbiter`

## Requirements
- R1: While reset is held and in the first cycles after it, `vdp_we`, `spr_ack`, `cpu_ack`, `dma_done` and `dram_rd` are all low.
- R2: When several masters are eligible at a free byte slot, the sprite master wins over the CPU and the CPU wins over the DMA engine. A master is not eligible in the cycle in which its own acknowledge is showing.
- R3: The two bytes of an address setup are consecutive port strobes. No data byte from any master is placed between them. Preemption happens only between whole bytes or whole setups.
- R4: An address setup is two strobes with `vdp_mode`=1: first the low address byte, then `{2'b01, addr[13:8]}`, where bits 7:6 = 01 mark a write setup. A setup is issued before a master's data whenever the port's loaded address is not that master's current context.
- R5: Each data byte a master writes lands at the address after its previous byte, with a wrap at 14 bits. This holds even when other masters cut in between two of its bytes.
- R6: Two successive port strobes are separated by at least `gap_cycles` idle cycles. A gap of 0 allows strobes on back-to-back cycles.
- R7: A master's acknowledge is a one-cycle pulse in the same cycle as the data strobe (`vdp_we`=1, `vdp_mode`=0) that carries its byte. At most one acknowledge is high in any cycle.
- R8: After `dma_start`, the engine reads `dma_len` bytes from DRAM at ascending addresses starting at `dma_src` and writes them to video memory starting at `dma_dst`. `dram_rd` and `dram_addr` stay steady until `dram_ack`.
- R9: A start with a nonzero length clears `dma_done` in the cycle after it is taken. `dma_done` then rises exactly one cycle after the strobe of the final DMA byte and stays high until the next start. A zero-length start sets `dma_done` in the cycle after it is taken.
- R10: A `dma_start` pulse that arrives while a transfer is running has no effect: no extra bytes and no change of destination.
- R11: A seek pulse sets a master's context address and causes no port access by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gap_cycles | input | GAP_W | Minimum idle cycles between port strobes |
| spr_req | input | 1 | Sprite master has a data byte to write |
| spr_data | input | 8 | Sprite master data byte |
| spr_seek | input | 1 | Load sprite context address |
| spr_seek_addr | input | VADDR_W | New sprite context address |
| spr_ack | output | 1 | Sprite byte written this cycle |
| cpu_req | input | 1 | CPU has a data byte to write |
| cpu_data | input | 8 | CPU data byte |
| cpu_seek | input | 1 | Load CPU context address |
| cpu_seek_addr | input | VADDR_W | New CPU context address |
| cpu_ack | output | 1 | CPU byte written this cycle |
| dma_start | input | 1 | Start a block copy (ignored while busy) |
| dma_src | input | DRAM_AW | DRAM source start address |
| dma_dst | input | VADDR_W | Video memory destination start address |
| dma_len | input | LEN_W | Number of bytes to copy |
| dma_done | output | 1 | Sticky copy-complete status |
| dram_rd | output | 1 | DRAM read request, held until acknowledged |
| dram_addr | output | DRAM_AW | DRAM read address |
| dram_ack | input | 1 | DRAM read data valid |
| dram_rdata | input | 8 | DRAM read data |
| vdp_we | output | 1 | Port write strobe, one cycle per byte |
| vdp_mode | output | 1 | 1 = address setup byte, 0 = data byte |
| vdp_wdata | output | 8 | Port write byte |

## Verification
A request seen at a clock edge where the gap counter is zero produces its strobe, and for data also its acknowledge, in the cycle that follows. The next strobe can come no sooner than `gap_cycles`+1 cycles later. A DMA byte therefore needs a DRAM round trip plus one arbitration slot, and `dma_done` appears one cycle after the last DMA data strobe. The bench drives and samples on falling edges. A monitor replays every strobe into a model of the video memory with its own auto-increment, and checks gap spacing, setup encoding and acknowledge alignment cycle by cycle. Memory contents are compared only after a master's final acknowledge or after `dma_done`.

// File: rtl/vdp_arb_pkg.sv
package vdp_arb_pkg;
   localparam int NUM_MASTERS = 3;
   localparam int MIDX_W      = 2;

   // index order doubles as priority order: lowest index wins
   typedef enum logic [MIDX_W-1:0] {
      MST_SPR = 2'd0,
      MST_CPU = 2'd1,
      MST_DMA = 2'd2
   } master_e;

   typedef enum logic [1:0] {
      DMA_IDLE  = 2'd0,
      DMA_FETCH = 2'd1,
      DMA_OFFER = 2'd2
   } dma_state_e;

   localparam logic [1:0] SETUP_WR_FLAG = 2'b01;
endpackage

// File: rtl/vdp_arb_ctx.sv
module vdp_arb_ctx #(
   parameter int N       = 3,
   parameter int VADDR_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N-1:0]       seek,
   input  logic [VADDR_W-1:0] seek_addr [N],
   input  logic [N-1:0]       inc,
   output logic [VADDR_W-1:0] ctx       [N]
);
   // one shadow of the port's auto-incrementing address per master
   for (genvar g = 0; g < N; g++) begin : g_ctx
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ctx[g] <= '0;
         else if (seek[g]) ctx[g] <= seek_addr[g];
         else if (inc[g])  ctx[g] <= ctx[g] + 1'b1;
      end
   end
endmodule

// File: rtl/vdp_arb_dma.sv
module vdp_arb_dma
   import vdp_arb_pkg::*;
#(
   parameter int VADDR_W = 14,
   parameter int DRAM_AW = 20,
   parameter int LEN_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [DRAM_AW-1:0] src,
   input  logic [VADDR_W-1:0] dst,
   input  logic [LEN_W-1:0]   len,
   output logic               dram_rd,
   output logic [DRAM_AW-1:0] dram_addr,
   input  logic               dram_ack,
   input  logic [7:0]         dram_rdata,
   output logic               port_req,
   output logic [7:0]         port_data,
   input  logic               grant,
   output logic               ctx_seek,
   output logic [VADDR_W-1:0] ctx_addr,
   output logic               done
);
   dma_state_e         state;
   logic [LEN_W-1:0]   remain;
   logic [7:0]         hold;
   logic               take;

   assign take      = start && (state == DMA_IDLE);
   assign ctx_seek  = take;
   assign ctx_addr  = dst;
   assign dram_rd   = (state == DMA_FETCH);
   assign port_req  = (state == DMA_OFFER);
   assign port_data = hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= DMA_IDLE;
         remain    <= '0;
         hold      <= '0;
         dram_addr <= '0;
         done      <= 1'b0;
      end else begin
         case (state)
            DMA_IDLE: if (take) begin
               dram_addr <= src;
               remain    <= len;
               done      <= (len == '0);
               state     <= (len == '0) ? DMA_IDLE : DMA_FETCH;
            end
            DMA_FETCH: if (dram_ack) begin
               hold      <= dram_rdata;
               dram_addr <= dram_addr + 1'b1;
               state     <= DMA_OFFER;
            end
            DMA_OFFER: if (grant) begin
               remain <= remain - 1'b1;
               if (remain == LEN_W'(1)) begin
                  done  <= 1'b1;
                  state <= DMA_IDLE;
               end else begin
                  state <= DMA_FETCH;
               end
            end
            default: state <= DMA_IDLE;
         endcase
      end
   end

   // R8: a read stays posted with a steady address until answered
   a_r8_dram_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dram_rd && !dram_ack |=> dram_rd && $stable(dram_addr));
   // R9: an accepted nonzero start leaves the flag low
   a_r9_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
      start && (state == DMA_IDLE) && (len != '0) |=> !done);
   // R10: a start during a running copy leaves the byte count alone
   a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      start && (state == DMA_FETCH) |=> remain == $past(remain));
endmodule

// File: rtl/vdp_port_arbiter.sv
module vdp_port_arbiter
   import vdp_arb_pkg::*;
#(
   parameter int VADDR_W = 14,
   parameter int DRAM_AW = 20,
   parameter int LEN_W   = 16,
   parameter int GAP_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [GAP_W-1:0]   gap_cycles,
   input  logic               spr_req,
   input  logic [7:0]         spr_data,
   input  logic               spr_seek,
   input  logic [VADDR_W-1:0] spr_seek_addr,
   output logic               spr_ack,
   input  logic               cpu_req,
   input  logic [7:0]         cpu_data,
   input  logic               cpu_seek,
   input  logic [VADDR_W-1:0] cpu_seek_addr,
   output logic               cpu_ack,
   input  logic               dma_start,
   input  logic [DRAM_AW-1:0] dma_src,
   input  logic [VADDR_W-1:0] dma_dst,
   input  logic [LEN_W-1:0]   dma_len,
   output logic               dma_done,
   output logic               dram_rd,
   output logic [DRAM_AW-1:0] dram_addr,
   input  logic               dram_ack,
   input  logic [7:0]         dram_rdata,
   output logic               vdp_we,
   output logic               vdp_mode,
   output logic [7:0]         vdp_wdata
);
   localparam int N      = NUM_MASTERS;
   localparam int IDLE_W = GAP_W + 1;
   localparam int HI_W   = (VADDR_W > 8) ? VADDR_W - 8 : 1;

   if (VADDR_W < 9 || VADDR_W > 14) begin : g_bad_vaddr
      $error("VADDR_W must lie in 9..14 to fit the two-byte setup");
   end
   if (GAP_W < 1 || LEN_W < 1 || DRAM_AW < 1) begin : g_bad_width
      $error("GAP_W, LEN_W and DRAM_AW must be positive");
   end

   logic [N-1:0]       req_v, seek_v, inc_v, ack_q, cand;
   logic [VADDR_W-1:0] seek_addr_v [N];
   logic [VADDR_W-1:0] ctx_v       [N];
   logic [7:0]         data_v      [N];
   logic               dma_req, dma_seek;
   logic [7:0]         dma_data;
   logic [VADDR_W-1:0] dma_seek_addr;

   logic [GAP_W-1:0]   gap_cnt;
   logic               slot, hi_pend, loaded_vld, hit;
   logic [MIDX_W-1:0]  win, cur, loaded_id;
   logic [5:0]         hi_bits;

   assign req_v  = {dma_req, cpu_req, spr_req};
   assign seek_v = {dma_seek, cpu_seek, spr_seek};
   assign seek_addr_v[MST_SPR] = spr_seek_addr;
   assign seek_addr_v[MST_CPU] = cpu_seek_addr;
   assign seek_addr_v[MST_DMA] = dma_seek_addr;
   assign data_v[MST_SPR] = spr_data;
   assign data_v[MST_CPU] = cpu_data;
   assign data_v[MST_DMA] = dma_data;
   assign spr_ack = ack_q[MST_SPR];
   assign cpu_ack = ack_q[MST_CPU];

   vdp_arb_ctx #(.N(N), .VADDR_W(VADDR_W)) i_ctx (
      .clk(clk), .rst_n(rst_n), .seek(seek_v), .seek_addr(seek_addr_v),
      .inc(inc_v), .ctx(ctx_v));

   vdp_arb_dma #(.VADDR_W(VADDR_W), .DRAM_AW(DRAM_AW), .LEN_W(LEN_W)) i_dma (
      .clk(clk), .rst_n(rst_n), .start(dma_start), .src(dma_src),
      .dst(dma_dst), .len(dma_len), .dram_rd(dram_rd), .dram_addr(dram_addr),
      .dram_ack(dram_ack), .dram_rdata(dram_rdata), .port_req(dma_req),
      .port_data(dma_data), .grant(ack_q[MST_DMA]), .ctx_seek(dma_seek),
      .ctx_addr(dma_seek_addr), .done(dma_done));

   // a master whose ack is showing has not yet had a chance to move on
   assign cand = req_v & ~ack_q;
   always_comb begin
      win = MIDX_W'(MST_DMA);
      for (int i = N - 1; i >= 0; i--)
         if (cand[i]) win = MIDX_W'(i);
   end

   assign slot = (gap_cnt == '0);
   assign hit  = loaded_vld && (loaded_id == win);

   always_comb begin
      inc_v = '0;
      if (slot && !hi_pend && (|cand) && hit) inc_v[win] = 1'b1;
   end

   assign hi_bits = 6'(ctx_v[cur][VADDR_W-1 -: HI_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_cnt    <= '0;
         hi_pend    <= 1'b0;
         cur        <= '0;
         loaded_vld <= 1'b0;
         loaded_id  <= '0;
         ack_q      <= '0;
         vdp_we     <= 1'b0;
         vdp_mode   <= 1'b0;
         vdp_wdata  <= '0;
      end else begin
         vdp_we <= 1'b0;
         ack_q  <= '0;
         if (!slot) gap_cnt <= gap_cnt - 1'b1;
         if (slot && hi_pend) begin
            vdp_we     <= 1'b1;
            vdp_mode   <= 1'b1;
            vdp_wdata  <= {SETUP_WR_FLAG, hi_bits};
            hi_pend    <= 1'b0;
            loaded_vld <= 1'b1;
            loaded_id  <= cur;
            gap_cnt    <= gap_cycles;
         end else if (slot && (|cand)) begin
            vdp_we  <= 1'b1;
            gap_cnt <= gap_cycles;
            if (hit) begin
               vdp_mode   <= 1'b0;
               vdp_wdata  <= data_v[win];
               ack_q[win] <= 1'b1;
            end else begin
               vdp_mode  <= 1'b1;
               vdp_wdata <= ctx_v[win][7:0];
               hi_pend   <= 1'b1;
               cur       <= win;
            end
         end
         // a moved context no longer matches what the port holds
         if (seek_v[loaded_id]) loaded_vld <= 1'b0;
      end
   end

   // ---- checking state kept beside the sequencer ----
   logic              lo_seen, any_strobe;
   logic [IDLE_W-1:0] idle;
   logic [GAP_W-1:0]  gap_lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_seen    <= 1'b0;
         any_strobe <= 1'b0;
         idle       <= '0;
         gap_lat    <= '0;
      end else begin
         if (vdp_we && vdp_mode) lo_seen <= ~lo_seen;
         if (vdp_we) begin
            any_strobe <= 1'b1;
            idle       <= '0;
            gap_lat    <= gap_cycles;
         end else if (idle != {IDLE_W{1'b1}}) begin
            idle <= idle + 1'b1;
         end
      end
   end

   // R3: the high setup byte directly follows the low one
   a_r3_setup_pair: assert property (@(posedge clk) disable iff (!rst_n)
      vdp_we && lo_seen |-> vdp_mode);
   // R4: second setup byte carries the write flag in bits 7:6
   a_r4_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
      vdp_we && vdp_mode && lo_seen |-> vdp_wdata[7:6] == 2'b01);
   // R6: spacing between strobes
   a_r6_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
      vdp_we && any_strobe |-> idle >= IDLE_W'(gap_lat));
   // R7: at most one acknowledge, and only with a data strobe
   a_r7_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_q));
   a_r7_ack_data: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack_q) |-> vdp_we && !vdp_mode);
   // R2: the copy engine never wins over an eligible sprite or CPU request
   a_r2_dma_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q[MST_DMA] |-> !$past(spr_req && !spr_ack) && !$past(cpu_req && !cpu_ack));
endmodule

// File: tb/test_vdp_port_arbiter.sv
`timescale 1ns/1ps
module test_vdp_port_arbiter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  gap_cycles = '0;
   logic        spr_req = 0, spr_seek = 0, cpu_req = 0, cpu_seek = 0;
   logic [7:0]  spr_data = '0, cpu_data = '0;
   logic [13:0] spr_seek_addr = '0, cpu_seek_addr = '0, dma_dst = '0;
   logic        spr_ack, cpu_ack, dma_done, dram_rd, vdp_we, vdp_mode;
   logic        dma_start = 0;
   logic [19:0] dma_src = '0, dram_addr;
   logic [15:0] dma_len = '0;
   logic        dram_ack;
   logic [7:0]  dram_rdata, vdp_wdata;

   always #2 clk = ~clk;

   vdp_port_arbiter i_vdp_port_arbiter (
      .clk(clk), .rst_n(rst_n), .gap_cycles(gap_cycles),
      .spr_req(spr_req), .spr_data(spr_data), .spr_seek(spr_seek),
      .spr_seek_addr(spr_seek_addr), .spr_ack(spr_ack),
      .cpu_req(cpu_req), .cpu_data(cpu_data), .cpu_seek(cpu_seek),
      .cpu_seek_addr(cpu_seek_addr), .cpu_ack(cpu_ack),
      .dma_start(dma_start), .dma_src(dma_src), .dma_dst(dma_dst),
      .dma_len(dma_len), .dma_done(dma_done), .dram_rd(dram_rd),
      .dram_addr(dram_addr), .dram_ack(dram_ack), .dram_rdata(dram_rdata),
      .vdp_we(vdp_we), .vdp_mode(vdp_mode), .vdp_wdata(vdp_wdata));

   int n_cmp = 0, n_bad = 0;
   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // DRAM model: answers two cycles after a read is posted
   logic [1:0] dly;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dram_ack <= 1'b0; dram_rdata <= '0; dly <= '0;
      end else if (dram_rd && !dram_ack) begin
         if (dly == 2'd1) begin
            dram_ack <= 1'b1; dram_rdata <= dram_addr[7:0] ^ 8'h5A; dly <= '0;
         end else dly <= dly + 1'b1;
      end else dram_ack <= 1'b0;
   end

   // port monitor: a model of video memory with its own auto-increment
   int   cyc = 0;
   always @(posedge clk) cyc++;
   byte unsigned vram [int];
   bit   mon_on = 0, hi_exp = 0, seen = 0, done_prev = 0;
   int   last_cyc = 0, last_dma = 0, dma_strobes = 0, cur_gap = 0;
   int   vaddr = 0;
   logic [7:0] lo_b;
   always @(negedge clk) if (mon_on) begin
      if (spr_ack || cpu_ack)
         chk(vdp_we && !vdp_mode && !(spr_ack && cpu_ack), "R7 ack with data strobe",
             {vdp_we, vdp_mode}, 2);
      if (vdp_we) begin
         if (seen) chk(cyc - last_cyc - 1 >= cur_gap, "R6 gap", cyc - last_cyc - 1, cur_gap);
         last_cyc = cyc; seen = 1;
         if (vdp_mode) begin
            if (!hi_exp) begin lo_b = vdp_wdata; hi_exp = 1; end
            else begin
               chk(vdp_wdata[7:6] == 2'b01, "R4 setup flag", vdp_wdata[7:6], 1);
               vaddr = {vdp_wdata[5:0], lo_b}; hi_exp = 0;
            end
         end else begin
            chk(!hi_exp, "R3 data inside setup", hi_exp, 0);
            vram[vaddr] = vdp_wdata;
            vaddr = (vaddr + 1) & 16'h3FFF;
            if (!spr_ack && !cpu_ack) begin dma_strobes++; last_dma = cyc; end
         end
      end
      if (dma_done && !done_prev && dma_strobes > 0)
         chk(cyc == last_dma + 1, "R9 done one cycle after last byte", cyc, last_dma + 1);
      done_prev = dma_done;
   end

   function automatic int rd(input int a);
      return vram.exists(a) ? int'(vram[a]) : -1;
   endfunction

   task automatic set_gap(input int g);
      @(negedge clk); gap_cycles = 4'(g); cur_gap = g;
   endtask

   task automatic spr_burst(input logic [13:0] a, input logic [7:0] d0, input int n);
      @(negedge clk); spr_seek = 1; spr_seek_addr = a;
      @(negedge clk); spr_seek = 0;
      for (int i = 0; i < n; i++) begin
         spr_req = 1; spr_data = d0 + 8'(i);
         do @(negedge clk); while (!spr_ack);
      end
      spr_req = 0;
   endtask

   task automatic cpu_burst(input logic [13:0] a, input logic [7:0] d0, input int n);
      @(negedge clk); cpu_seek = 1; cpu_seek_addr = a;
      @(negedge clk); cpu_seek = 0;
      for (int i = 0; i < n; i++) begin
         cpu_req = 1; cpu_data = d0 + 8'(i);
         do @(negedge clk); while (!cpu_ack);
      end
      cpu_req = 0;
   endtask

   task automatic pulse_start(input logic [19:0] s, input logic [13:0] d, input int n);
      @(negedge clk); dma_start = 1; dma_src = s; dma_dst = d; dma_len = 16'(n);
      @(negedge clk); dma_start = 0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // CPU bursts: gap[31:28] addr[27:14] data[13:6] len[5:0]
   localparam logic [31:0] TBL [5] = '{
      {4'd0, 14'h0100, 8'h11, 6'd5},
      {4'd1, 14'h0155, 8'h21, 6'd4},
      {4'd3, 14'h02FE, 8'h31, 6'd6},
      {4'd2, 14'h3FFE, 8'h41, 6'd4},
      {4'd0, 14'h1FF0, 8'h51, 6'd3}
   };

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
   end

   initial begin
      int s_last, c_first;
      // R1: quiet during and after reset
      repeat (3) @(negedge clk);
      chk({vdp_we, spr_ack, cpu_ack, dma_done, dram_rd} == 0, "R1 in reset",
          {vdp_we, spr_ack, cpu_ack, dma_done, dram_rd}, 0);
      rst_n = 1; mon_on = 1;
      repeat (4) @(negedge clk);
      chk({vdp_we, spr_ack, cpu_ack, dma_done, dram_rd} == 0, "R1 after reset",
          {vdp_we, spr_ack, cpu_ack, dma_done, dram_rd}, 0);

      // R5/R4/R6: table of CPU bursts, including a 14-bit wrap
      foreach (TBL[k]) begin
         set_gap(int'(TBL[k][31:28]));
         cpu_burst(TBL[k][27:14], TBL[k][13:6], int'(TBL[k][5:0]));
         repeat (20) @(negedge clk);
         for (int i = 0; i < int'(TBL[k][5:0]); i++)
            chk(rd((int'(TBL[k][27:14]) + i) & 16'h3FFF) == int'(8'(TBL[k][13:6] + 8'(i))),
                "R5 burst byte", rd((int'(TBL[k][27:14]) + i) & 16'h3FFF),
                int'(8'(TBL[k][13:6] + 8'(i))));
      end

      // R11: a seek alone makes no port access
      set_gap(0);
      @(negedge clk); cpu_seek = 1; cpu_seek_addr = 14'h0777;
      @(negedge clk); cpu_seek = 0;
      begin
         int n_we = 0;
         for (int i = 0; i < 6; i++) begin @(negedge clk); if (vdp_we) n_we++; end
         chk(n_we == 0, "R11 seek without strobe", n_we, 0);
      end

      // R2: simultaneous sprite and CPU requests
      set_gap(5);
      s_last = 0; c_first = 0;
      fork
         spr_burst(14'h3000, 8'hA0, 3);
         cpu_burst(14'h1100, 8'hB0, 3);
         begin
            do @(negedge clk); while (!(spr_ack || cpu_ack));
            chk(spr_ack && !cpu_ack, "R2 sprite first", {spr_ack, cpu_ack}, 2);
         end
         begin
            for (int i = 0; i < 3; i++) begin
               do @(negedge clk); while (!spr_ack);
               s_last = cyc;
            end
         end
         begin
            do @(negedge clk); while (!cpu_ack);
            c_first = cyc;
         end
      join
      chk(c_first > s_last, "R2 CPU waits for sprite stream", c_first, s_last + 1);
      repeat (10) @(negedge clk);
      chk(rd(16'h3002) == 8'hA2 && rd(16'h1102) == 8'hB2, "R2 both streams land",
          rd(16'h1102), 8'hB2);

      // R3/R5/R8/R9/R10: copy preempted by CPU, CPU preempted by sprite
      set_gap(2);
      dma_strobes = 0;
      fork
         begin
            pulse_start(20'h00100, 14'h2F00, 24);
            chk(!dma_done, "R9 cleared by start", dma_done, 0);
            do @(negedge clk); while (!dma_done);
         end
         begin repeat (12) @(negedge clk); pulse_start(20'h00000, 14'h2000, 5); end
         begin repeat (30) @(negedge clk); cpu_burst(14'h1234, 8'h40, 8); end
         begin repeat (45) @(negedge clk); spr_burst(14'h3F10, 8'hC0, 4); end
      join
      repeat (10) @(negedge clk);
      for (int i = 0; i < 24; i++)
         chk(rd(16'h2F00 + i) == int'(8'(20'h100 + i) ^ 8'h5A), "R8 copy byte",
             rd(16'h2F00 + i), int'(8'(20'h100 + i) ^ 8'h5A));
      for (int i = 0; i < 8; i++)
         chk(rd(16'h1234 + i) == int'(8'h40 + i), "R5 resumed CPU byte",
             rd(16'h1234 + i), int'(8'h40 + i));
      for (int i = 0; i < 4; i++)
         chk(rd(16'h3F10 + i) == int'(8'hC0 + i), "R5 sprite byte",
             rd(16'h3F10 + i), int'(8'hC0 + i));
      chk(dma_strobes == 24, "R10 busy start adds no bytes", dma_strobes, 24);
      chk(rd(16'h2000) == -1, "R10 busy start destination untouched", rd(16'h2000), -1);
      chk(dma_done, "R9 done holds", dma_done, 1);

      // R9: zero-length copy completes at once
      pulse_start(20'h00000, 14'h2800, 0);
      chk(dma_done, "R9 zero length done", dma_done, 1);
      repeat (5) @(negedge clk);
      chk(rd(16'h2800) == -1, "R9 zero length writes nothing", rd(16'h2800), -1);

      summary();
   end
endmodule